// File: doc/BRIEF.md
# Dual-Form Four-Bit LFSR Sequence Generator

This block steps a four-bit linear-feedback shift register through the maximal-length sequence of the polynomial x^4 + x^3 + 1, which visits all fifteen non-zero states before it repeats. The same register can be built from one of two tap arrangements. The external (Fibonacci) form gathers the feedback into one XOR at the bottom of the register. The internal (Galois) form puts each XOR between two neighbouring flops, so no flop-to-flop path is deeper than one gate. A form select is sampled only when the register is reset or loaded.

The generator serves as a counter with no carry chain and as a cheap pseudo-random source whose output can be reproduced. The state is advanced by a step enable. A load strobe restarts the sequence from a chosen seed, and a seed of zero is replaced by 1111 because all-zero is a lock-up state. A wrap flag marks each step that brings the register back to the last loaded seed.

Top module: `lfsr_dualform`

## Requirements
- R1: While rst_i is high at a rising edge, the state becomes 1111, the remembered seed becomes 1111, the form is taken from form_i, and wrap_o is 0 in the next cycle.
- R2: In the external form (form_i = 0 at the last reset or load), an enabled step gives next = {s[2:0], s[3] XOR s[2]}. From 1111 the states are 1110, 1100, 1000, 0001, 0010, 0100, 1001, 0011, 0110, 1101, 1010, 0101, 1011, 0111, 1111.
- R3: In the internal form (form_i = 1), an enabled step shifts toward the MSB with a 0 entering bit 0, and XORs in 1001 when the outgoing bit 3 was 1. From 1111 the states are 0111, 1110, 0101, 1010, 1101, 0011, 0110, 1100, 0001, 0010, 0100, 1000, 1001, 1011, 1111.
- R4: In both forms, stepping from any non-zero seed returns to that seed after exactly 15 steps, and the state is never 0000.
- R5: When load_i is high at an edge, the state and the remembered seed take seed_i. If seed_i is 0000, they take 1111 instead.
- R6: When load_i and step_i are both high, the load wins and no step is taken.
- R7: With load_i and step_i both low, the state holds.
- R8: wrap_o is high for exactly the one cycle after an enabled step whose result equals the remembered seed. Otherwise it is low, including after a load or a reset.
- R9: serial_o always equals bit 3 of state_o.
- R10: A change of form_i has no effect unless rst_i or load_i is high at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Advance the register one step |
| load_i | input | 1 | Load seed_i and sample form_i |
| seed_i | input | 4 | Seed value; 0000 is replaced by 1111 |
| form_i | input | 1 | 0 = external feedback, 1 = internal feedback |
| state_o | output | 4 | Current register state |
| serial_o | output | 1 | Serial bit, state bit 3 |
| wrap_o | output | 1 | One-cycle flag when a step returns to the seed |

## Verification
The bench builds the block with its default RESET_SEED of 1111. With that value, the state that follows reset is the starting point of both fifteen-step sequences, and the walks from reset can be compared state by state with the listed orders. Reloading arbitrary seeds, including 0000, then reaches every other offset in the cycle, the wrap timing from each of them, and form changes made with and without a load.

// File: rtl/lfsr_pkg.sv
`timescale 1ns/1ps
package lfsr_pkg;

    localparam int unsigned STATE_W = 4;

    // External form: the bits XORed into the new bit 0 (x^4 and x^3 terms)
    localparam logic [STATE_W-1:0] FIB_TAPS    = 4'b1100;
    // Internal form: the mask XORed in when the outgoing MSB is 1
    localparam logic [STATE_W-1:0] GALOIS_MASK = 4'b1001;
    // Value that stands in for the forbidden all-zero seed
    localparam logic [STATE_W-1:0] SAFE_SEED   = '1;

    typedef enum logic {
        FORM_EXT = 1'b0,
        FORM_INT = 1'b1
    } fb_form_e;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic [STATE_W-1:0] seed;
        fb_form_e           form;
        logic               wrap;
    } lfsr_regs_t;

endpackage

// File: rtl/lfsr_fib_step.sv
`timescale 1ns/1ps
module lfsr_fib_step
    import lfsr_pkg::*;
#(
    parameter logic [STATE_W-1:0] TAPS = FIB_TAPS
) (
    input  logic [STATE_W-1:0] cur_i,
    output logic [STATE_W-1:0] nxt_o
);
    logic feedback;

    always_comb begin
        feedback = ^(cur_i & TAPS);
        nxt_o    = {cur_i[STATE_W-2:0], feedback};
    end
endmodule

// File: rtl/lfsr_galois_step.sv
`timescale 1ns/1ps
module lfsr_galois_step
    import lfsr_pkg::*;
#(
    parameter logic [STATE_W-1:0] MASK = GALOIS_MASK
) (
    input  logic [STATE_W-1:0] cur_i,
    output logic [STATE_W-1:0] nxt_o
);
    logic outgoing;
    assign outgoing = cur_i[STATE_W-1];

    for (genvar i = 0; i < STATE_W; i++) begin : g_bit
        if (i == 0) begin : g_low
            if (MASK[0]) begin : g_tap
                assign nxt_o[0] = outgoing;
            end else begin : g_none
                assign nxt_o[0] = 1'b0;
            end
        end else begin : g_high
            if (MASK[i]) begin : g_tap
                assign nxt_o[i] = cur_i[i-1] ^ outgoing;
            end else begin : g_none
                assign nxt_o[i] = cur_i[i-1];
            end
        end
    end
endmodule

// File: rtl/lfsr_seed_guard.sv
`timescale 1ns/1ps
module lfsr_seed_guard
    import lfsr_pkg::*;
(
    input  logic [STATE_W-1:0] raw_i,
    output logic [STATE_W-1:0] safe_o
);
    always_comb begin
        safe_o = (raw_i == '0) ? SAFE_SEED : raw_i;
    end
endmodule

// File: rtl/lfsr_dualform.sv
`timescale 1ns/1ps
module lfsr_dualform
    import lfsr_pkg::*;
#(
    parameter logic [STATE_W-1:0] RESET_SEED = 4'b1111
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               step_i,
    input  logic               load_i,
    input  logic [STATE_W-1:0] seed_i,
    input  logic               form_i,
    output logic [STATE_W-1:0] state_o,
    output logic               serial_o,
    output logic               wrap_o
);
    localparam logic [STATE_W-1:0] RST_VAL = (RESET_SEED == '0) ? SAFE_SEED : RESET_SEED;

    lfsr_regs_t regs_d, regs_q;

    logic [STATE_W-1:0] fib_nxt;
    logic [STATE_W-1:0] gal_nxt;
    logic [STATE_W-1:0] step_nxt;
    logic [STATE_W-1:0] load_val;
    logic               form_int_q;

    assign form_int_q = (regs_q.form == FORM_INT);

    lfsr_fib_step #(.TAPS(FIB_TAPS)) fib_i (
        .cur_i (regs_q.state),
        .nxt_o (fib_nxt)
    );

    lfsr_galois_step #(.MASK(GALOIS_MASK)) gal_i (
        .cur_i (regs_q.state),
        .nxt_o (gal_nxt)
    );

    lfsr_seed_guard guard_i (
        .raw_i  (seed_i),
        .safe_o (load_val)
    );

    assign step_nxt = form_int_q ? gal_nxt : fib_nxt;

    always_comb begin
        regs_d      = regs_q;
        regs_d.wrap = 1'b0;
        if (load_i) begin
            regs_d.state = load_val;
            regs_d.seed  = load_val;
            regs_d.form  = fb_form_e'(form_i);
        end else if (step_i) begin
            regs_d.state = step_nxt;
            regs_d.wrap  = (step_nxt == regs_q.seed);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            regs_q.state <= RST_VAL;
            regs_q.seed  <= RST_VAL;
            regs_q.form  <= fb_form_e'(form_i);
            regs_q.wrap  <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o  = regs_q.state;
    assign serial_o = regs_q.state[STATE_W-1];
    assign wrap_o   = regs_q.wrap;

endmodule

// File: rtl/lfsr_dualform_chk.sv
`timescale 1ns/1ps
module lfsr_dualform_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       step_i,
    input logic       load_i,
    input logic [3:0] seed_i,
    input logic       form_int_q,
    input logic [3:0] state_o,
    input logic       wrap_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        rst_i |=> (state_o == 4'b1111 && !wrap_o));

    // R4
    never_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        state_o != 4'b0000);

    // R5
    load_seed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && seed_i != 4'b0000) |=> (state_o == $past(seed_i) && !wrap_o));

    // R5
    zero_seed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && seed_i == 4'b0000) |=> (state_o == 4'b1111));

    // R7
    hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !step_i) |=> ($stable(state_o) && !wrap_o));

    // R8
    wrap_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> !wrap_o);

    // R2
    ext_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && step_i && !form_int_q) |=>
            (state_o == {$past(state_o[2:0]), $past(state_o[3]) ^ $past(state_o[2])}));

    // R3
    int_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && step_i && form_int_q) |=>
            (state_o == ({$past(state_o[2:0]), 1'b0} ^ ($past(state_o[3]) ? 4'b1001 : 4'b0000))));
endmodule

bind lfsr_dualform lfsr_dualform_chk chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .step_i     (step_i),
    .load_i     (load_i),
    .seed_i     (seed_i),
    .form_int_q (form_int_q),
    .state_o    (state_o),
    .wrap_o     (wrap_o)
);

// File: tb/lfsr_dualform_tb_top.sv
`timescale 1ns/1ps
module lfsr_dualform_tb_top;

    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       step_i = 1'b0;
    logic       load_i = 1'b0;
    logic [3:0] seed_i = 4'h0;
    logic       form_i = 1'b0;
    logic [3:0] state_o;
    logic       serial_o;
    logic       wrap_o;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;

    // Bench model
    logic [3:0] m_state = 4'hF;
    logic [3:0] m_seed  = 4'hF;
    logic       m_form  = 1'b0;
    logic       m_wrap  = 1'b0;

    always #5 clk = ~clk;

    lfsr_dualform dut_i (
        .clk_i    (clk),
        .rst_i    (rst_i),
        .step_i   (step_i),
        .load_i   (load_i),
        .seed_i   (seed_i),
        .form_i   (form_i),
        .state_o  (state_o),
        .serial_o (serial_o),
        .wrap_o   (wrap_o)
    );

    function automatic logic [3:0] ext_next(input logic [3:0] s);
        return {s[2:0], s[3] ^ s[2]};
    endfunction

    function automatic logic [3:0] int_next(input logic [3:0] s);
        logic [3:0] sh;
        sh = {s[2:0], 1'b0};
        return s[3] ? (sh ^ 4'b1001) : sh;
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic rs, input logic ld, input logic en,
                       input logic [3:0] sd, input logic fm);
        string tag;
        logic  form_ignored;
        @(negedge clk);
        rst_i = rs; load_i = ld; step_i = en; seed_i = sd; form_i = fm;
        @(posedge clk);
        #1;
        form_ignored = !rs && !ld && (fm != m_form);
        if (rs) begin
            m_state = 4'hF; m_seed = 4'hF; m_form = fm; m_wrap = 1'b0; tag = "R1";
        end else if (ld) begin
            m_state = (sd == 4'h0) ? 4'hF : sd;
            m_seed = m_state; m_form = fm; m_wrap = 1'b0;
            tag = en ? "R6" : "R5";
        end else if (en) begin
            m_state = m_form ? int_next(m_state) : ext_next(m_state);
            m_wrap = (m_state == m_seed);
            tag = m_form ? "R3" : "R2";
        end else begin
            m_wrap = 1'b0; tag = "R7";
        end
        if (form_ignored) tag = {tag, "/R10"};
        check({tag, " state"}, state_o, m_state);
        check("R8 wrap", {3'b0, wrap_o}, {3'b0, m_wrap});
        check("R9 serial", {3'b0, serial_o}, {3'b0, state_o[3]});
    endtask

    // Walk from a seed: checks period 15, no zero state, wrap only at the end
    task automatic walk(input logic [3:0] sd, input logic fm);
        int steps = 0;
        logic [3:0] start;
        cyc(1'b0, 1'b1, 1'b0, sd, fm);
        start = state_o;
        for (int k = 0; k < 15; k++) begin
            cyc(1'b0, 1'b0, 1'b1, 4'h0, fm);
            steps++;
            check("R4 nonzero", {3'b0, state_o == 4'h0}, 4'h0);
            if (state_o == start) break;
        end
        check("R4 period", steps[3:0], 4'd15);
        check("R8 wrap at period", {3'b0, wrap_o}, 4'h1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [3:0] ext_tab [15];
        logic [3:0] int_tab [15];
        void'($urandom(32'h5eed_1234));
        ext_tab = '{4'hE, 4'hC, 4'h8, 4'h1, 4'h2, 4'h4, 4'h9, 4'h3,
                    4'h6, 4'hD, 4'hA, 4'h5, 4'hB, 4'h7, 4'hF};
        int_tab = '{4'h7, 4'hE, 4'h5, 4'hA, 4'hD, 4'h3, 4'h6, 4'hC,
                    4'h1, 4'h2, 4'h4, 4'h8, 4'h9, 4'hB, 4'hF};

        // R1: reset state, external form
        cyc(1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
        check("R1 reset state", state_o, 4'hF);
        check("R1 reset wrap", {3'b0, wrap_o}, 4'h0);

        // R2: external sequence against the literal table
        for (int k = 0; k < 15; k++) begin
            cyc(1'b0, 1'b0, 1'b1, 4'h0, 1'b0);
            check("R2 table", state_o, ext_tab[k]);
        end

        // R3: internal sequence from reset
        cyc(1'b1, 1'b0, 1'b0, 4'h0, 1'b1);
        for (int k = 0; k < 15; k++) begin
            cyc(1'b0, 1'b0, 1'b1, 4'h0, 1'b1);
            check("R3 table", state_o, int_tab[k]);
        end

        // R5: zero seed substitution, both forms
        cyc(1'b0, 1'b1, 1'b0, 4'h0, 1'b0);
        check("R5 zero seed ext", state_o, 4'hF);
        cyc(1'b0, 1'b1, 1'b0, 4'h0, 1'b1);
        check("R5 zero seed int", state_o, 4'hF);

        // R6: load wins over step
        cyc(1'b0, 1'b1, 1'b1, 4'h6, 1'b0);
        check("R6 load priority", state_o, 4'h6);

        // R7: hold
        cyc(1'b0, 1'b0, 1'b0, 4'h3, 1'b1);
        check("R7 hold", state_o, 4'h6);

        // R10: form change without load is ignored (still external)
        cyc(1'b0, 1'b0, 1'b1, 4'h0, 1'b1);
        check("R10 form ignored", state_o, 4'hD);

        // R4, R8: full walks from several seeds in both forms
        walk(4'h6, 1'b0);
        walk(4'h1, 1'b1);
        walk(4'h0, 1'b1);
        walk(4'hA, 1'b0);

        // Random mixture
        for (int k = 0; k < 3000; k++) begin
            logic rs, ld, en, fm;
            logic [3:0] sd;
            rs = ($urandom_range(0, 99) == 0);
            ld = ($urandom_range(0, 9) == 0);
            en = ($urandom_range(0, 3) != 0);
            sd = 4'($urandom_range(0, 15));
            fm = ($urandom_range(0, 7) == 0) ? ~m_form : m_form;
            cyc(rs, ld, en, sd, fm);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule